// File: doc/BRIEF.md
# Bit Error Rate Measurement Engine

This block measures the bit error rate of a serial radio link under test. The far end sends a fixed frame over and over with no gaps. Each frame is one alignment byte followed by 32 payload bytes whose values rise by one from the first byte to the last. The engine receives the demodulated data line and its data clock, both asynchronous to the system clock, and samples one bit per data-clock rising edge. It hunts for the alignment byte one bit at a time. It then compares every payload bit against a locally generated copy of the expected byte sequence, and after each frame it checks that the next frame's alignment byte follows at once.

Two saturating counters keep running totals: bits compared and bits in error. A request pulse copies both totals into holding registers that feed a seven-segment display driver. The shown numbers stay fixed while counting goes on. A clear pulse restarts the measurement.

Top module: `ber_engine`

## Requirements
- R1: After reset both running counters and both displayed values are zero, and the engine is hunting for alignment.
- R2: One bit is taken per rising edge of `rx_dclk`. The bit is the value of `rx_data` after the same synchronizer delay, so `rx_data` must be stable around each rising edge.
- R3: While hunting, the last eight received bits are checked after every bit. The alignment byte 0xAA, sent MSB first, is found at any bit offset. Bits received while hunting, including the alignment byte itself, are not counted.
- R4: The 256 bits after an alignment byte are compared MSB first against payload bytes 0x00, 0x01, ... 0x1F. Every compared bit increments the bit counter by one.
- R5: Every compared bit that differs from its expected value increments the error counter by one.
- R6: After the 256th payload bit, the next eight bits are checked against 0xAA. If they match, the next payload is compared at once, and those eight bits are not counted.
- R7: If the byte following a payload is not 0xAA, the engine returns to hunting. No bit is counted until a new 0xAA is found.
- R8: Both counters saturate at all ones and never wrap.
- R9: A `clr` pulse zeroes both running counters. The displayed values do not change until the next request.
- R10: A `show_req` pulse copies both running counters, as they stand at that clock edge, to `disp_bits` and `disp_errs`. At all other times the displayed values stay constant.
- R11: The error count never exceeds the bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dclk | input | 1 | Recovered data clock from the demodulator |
| rx_data | input | 1 | Demodulated serial data |
| clr | input | 1 | Synchronous clear of both running counters |
| show_req | input | 1 | Request to latch the counts for display |
| disp_bits | output | CNT_W | Latched count of compared bits |
| disp_errs | output | CNT_W | Latched count of bit errors |

## Verification
A wrong alignment state shows up at the display as a count that is off by whole frames. Missing a marker leaves 256 bits uncounted, and hunting during a payload causes a burst of errors. An off-by-one in the bit index or in the MSB-first order turns a clean frame into a nonzero error count. That error is visible at the first request after a single frame, roughly 264 data-clock periods later. A counter that wraps or ignores `clr` shows up at the first request after the event. The bench uses a narrow second instance so that saturation is reached within one frame.

// File: rtl/ber_pkg.sv
package ber_pkg;
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_CHECK  = 2'd1,
    ST_RESYNC = 2'd2
  } ber_state_e;

  localparam int unsigned LANE_BITS = 0;
  localparam int unsigned LANE_ERRS = 1;
  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/ber_edge_sync.sv
module ber_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_dclk,
  input  logic rx_data,
  output logic bit_stb,
  output logic bit_val
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] dclk_q;
  logic [SYNC_STAGES-1:0] data_q;
  logic                   dclk_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q    <= '0;
      data_q    <= '0;
      dclk_last <= 1'b0;
    end else begin
      dclk_q    <= {dclk_q[SYNC_STAGES-2:0], rx_dclk};
      data_q    <= {data_q[SYNC_STAGES-2:0], rx_data};
      dclk_last <= dclk_q[TOP];
    end
  end

  always_comb begin
    bit_stb = dclk_q[TOP] & ~dclk_last;
    bit_val = data_q[TOP];
  end

  // R2: a single data-clock edge yields exactly one bit strobe
  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/ber_framer.sv
module ber_framer
  import ber_pkg::*;
#(
  parameter logic [7:0]  MARK_BYTE  = 8'hAA,
  parameter int unsigned PAY_BYTES  = 32,
  parameter logic [7:0]  FIRST_BYTE = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic bit_val,
  output logic cmp_vld,
  output logic cmp_err
);
  localparam int unsigned PAY_BITS = PAY_BYTES * 8;
  localparam int unsigned IDX_W    = $clog2(PAY_BITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_BITS - 1);

  ber_state_e       state, state_nx;
  logic [7:0]       win, win_nx;
  logic [IDX_W-1:0] idx, idx_nx;
  logic [2:0]       rcnt, rcnt_nx;
  logic [7:0]       exp_byte;
  logic             exp_bit;
  logic             at_last;
  logic             mark_hit;

  always_comb begin
    win_nx   = bit_stb ? {win[6:0], bit_val} : win;
    mark_hit = ({win[6:0], bit_val} == MARK_BYTE);
    exp_byte = FIRST_BYTE + 8'(idx[IDX_W-1:3]);
    exp_bit  = exp_byte[3'd7 - idx[2:0]];
    at_last  = (idx == LAST_IDX);
  end

  always_comb begin
    state_nx = state;
    idx_nx   = idx;
    rcnt_nx  = rcnt;
    cmp_vld  = 1'b0;
    cmp_err  = 1'b0;
    if (bit_stb) begin
      case (state)
        ST_HUNT: begin
          if (mark_hit) begin
            state_nx = ST_CHECK;
            idx_nx   = '0;
          end
        end
        ST_CHECK: begin
          cmp_vld = 1'b1;
          cmp_err = bit_val ^ exp_bit;
          if (at_last) begin
            state_nx = ST_RESYNC;
            rcnt_nx  = '0;
          end else begin
            idx_nx = idx + IDX_W'(1);
          end
        end
        ST_RESYNC: begin
          rcnt_nx = rcnt + 3'd1;
          if (rcnt == 3'd7) begin
            idx_nx   = '0;
            state_nx = mark_hit ? ST_CHECK : ST_HUNT;
          end
        end
        default: state_nx = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      win   <= '0;
      idx   <= '0;
      rcnt  <= '0;
    end else begin
      state <= state_nx;
      win   <= win_nx;
      idx   <= idx_nx;
      rcnt  <= rcnt_nx;
    end
  end

  // R6: a finished payload is always followed by the marker check
  assert_resync_after_payload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CHECK && bit_stb && at_last) |=> (state == ST_RESYNC));
  // R3: hunting only ends on a marker match
  assert_hunt_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HUNT && !(bit_stb && mark_hit)) |=> (state == ST_HUNT));
  // R5: errors are only flagged on compared bits
  assert_err_needs_cmp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_err |-> cmp_vld);
  // R7: no comparison while hunting or resyncing
  assert_no_cmp_outside_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_CHECK) |-> !cmp_vld);
endmodule

// File: rtl/ber_counters.sv
module ber_counters
  import ber_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_bit,
  input  logic             inc_err,
  input  logic             snap,
  output logic [CNT_W-1:0] disp_bits,
  output logic [CNT_W-1:0] disp_errs
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_LANES-1:0] inc;
  logic [CNT_W-1:0]     live    [NUM_LANES];
  logic [CNT_W-1:0]     live_nx [NUM_LANES];
  logic [CNT_W-1:0]     hold    [NUM_LANES];

  always_comb begin
    inc[LANE_BITS] = inc_bit;
    inc[LANE_ERRS] = inc_err;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    always_comb begin
      if (clr)
        live_nx[g] = '0;
      else if (inc[g] && live[g] != CNT_MAX)
        live_nx[g] = live[g] + CNT_W'(1);
      else
        live_nx[g] = live[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live[g] <= '0;
        hold[g] <= '0;
      end else begin
        live[g] <= live_nx[g];
        if (snap) hold[g] <= live[g];
      end
    end

    // R8: a full counter stays full until cleared
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (live[g] == CNT_MAX && !clr) |=> (live[g] == CNT_MAX));
    // R10: displayed value only changes on a request
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !snap |=> $stable(hold[g]));
    // R9: clear empties the running counter
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (live[g] == '0));
  end

  always_comb begin
    disp_bits = hold[LANE_BITS];
    disp_errs = hold[LANE_ERRS];
  end

  // R11: errors never outnumber compared bits
  assert_errs_le_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    live[LANE_ERRS] <= live[LANE_BITS]);
endmodule

// File: rtl/ber_engine.sv
module ber_engine #(
  parameter logic [7:0]  MARK_BYTE   = 8'hAA,
  parameter int unsigned PAY_BYTES   = 32,
  parameter logic [7:0]  FIRST_BYTE  = 8'h00,
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_dclk,
  input  logic             rx_data,
  input  logic             clr,
  input  logic             show_req,
  output logic [CNT_W-1:0] disp_bits,
  output logic [CNT_W-1:0] disp_errs
);
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  logic       bit_stb;
  logic       bit_val;
  logic       cmp_vld;
  logic       cmp_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end

  always_comb rst_n_int = rst_pipe[1];

  ber_edge_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .rx_dclk (rx_dclk),
    .rx_data (rx_data),
    .bit_stb (bit_stb),
    .bit_val (bit_val)
  );

  ber_framer #(
    .MARK_BYTE  (MARK_BYTE),
    .PAY_BYTES  (PAY_BYTES),
    .FIRST_BYTE (FIRST_BYTE)
  ) u_framer (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .bit_stb (bit_stb),
    .bit_val (bit_val),
    .cmp_vld (cmp_vld),
    .cmp_err (cmp_err)
  );

  ber_counters #(
    .CNT_W (CNT_W)
  ) u_counters (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .clr       (clr),
    .inc_bit   (cmp_vld),
    .inc_err   (cmp_err),
    .snap      (show_req),
    .disp_bits (disp_bits),
    .disp_errs (disp_errs)
  );
endmodule

// File: tb/ber_engine_bench.sv
module ber_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SMALL_W    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_dclk = 1'b0;
  logic rx_data = 1'b0;
  logic clr = 1'b0;
  logic show_req = 1'b0;
  logic [31:0]        disp_bits, disp_errs;
  logic [SMALL_W-1:0] sm_bits, sm_errs;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ber_engine u_ber_engine (
    .clk(clk), .rst_n(rst_n), .rx_dclk(rx_dclk), .rx_data(rx_data),
    .clr(clr), .show_req(show_req), .disp_bits(disp_bits), .disp_errs(disp_errs));

  ber_engine #(.CNT_W(SMALL_W)) u_ber_engine_small (
    .clk(clk), .rst_n(rst_n), .rx_dclk(rx_dclk), .rx_data(rx_data),
    .clr(clr), .show_req(show_req), .disp_bits(sm_bits), .disp_errs(sm_errs));

  task automatic check(input string tag, input longint got, input longint exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk) rx_data = b;
    repeat (2) @(negedge clk);
    rx_dclk = 1'b1;
    repeat (3) @(negedge clk);
    rx_dclk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  // payload 0x00..0x1F MSB first; nflip errors at fixed positions, or all inverted
  task automatic send_payload(input int nflip, input bit invert);
    for (int i = 0; i < 256; i++) begin
      logic [7:0] by;
      logic       b;
      by = 8'(i / 8);
      b  = by[7 - (i % 8)];
      if (invert || (nflip >= 1 && i == 5) || (nflip >= 2 && i == 77) ||
          (nflip >= 3 && i == 200))
        b = ~b;
      send_bit(b);
    end
  endtask

  task automatic request();
    repeat (6) @(negedge clk);
    show_req = 1'b1;
    @(negedge clk) show_req = 1'b0;
  endtask

  task automatic t_reset();
    request();
    check("R1 bits after reset", disp_bits, 0);
    check("R1 errs after reset", disp_errs, 0);
  endtask

  task automatic t_clean_frame();
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    send_byte(8'hAA);
    send_payload(0, 1'b0);
    request();
    check("R3 R4 bits one frame", disp_bits, 256);
    check("R4 errs clean frame", disp_errs, 0);
    check("R8 small bits saturate", sm_bits, 15);
  endtask

  task automatic t_back_to_back();
    send_byte(8'hAA);
    send_payload(3, 1'b0);
    request();
    check("R6 bits second frame", disp_bits, 512);
    check("R5 errs three flips", disp_errs, 3);
  endtask

  task automatic t_lost_sync();
    send_byte(8'h0F);
    send_payload(0, 1'b0);
    request();
    check("R7 bits unchanged while hunting", disp_bits, 512);
    check("R7 errs unchanged while hunting", disp_errs, 3);
    send_byte(8'hAA);
    send_payload(0, 1'b0);
    request();
    check("R7 bits after reacquire", disp_bits, 768);
  endtask

  task automatic t_hold();
    send_byte(8'hAA);
    send_payload(1, 1'b0);
    repeat (6) @(negedge clk);
    check("R10 bits held without request", disp_bits, 768);
    check("R10 errs held without request", disp_errs, 3);
    request();
    check("R10 bits after request", disp_bits, 1024);
    check("R10 errs after request", disp_errs, 4);
  endtask

  task automatic t_saturate();
    send_byte(8'hAA);
    send_payload(0, 1'b1);
    request();
    check("R5 bits inverted frame", disp_bits, 1280);
    check("R5 errs inverted frame", disp_errs, 260);
    check("R8 small errs saturate", sm_errs, 15);
    check("R8 small bits stay full", sm_bits, 15);
  endtask

  task automatic t_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 display kept after clear", disp_bits, 1280);
    request();
    check("R9 bits cleared", disp_bits, 0);
    check("R9 errs cleared", disp_errs, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_clean_frame();
    t_back_to_back();
    t_lost_sync();
    t_hold();
    t_saturate();
    t_clear();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule